// File: doc/BRIEF.md
# Keyed Commit Guard for Alternate-Function Select

This block protects a per-pin alternate-function select register behind two stages of write protection. A lock flag comes out of reset set. Software clears it by writing one fixed 32-bit key value to the lock register. While the flag is clear, software may load a commit mask. The commit mask then sets, bit by bit, which alternate-function bits a write may change. Alternate-function bits whose commit bit is zero keep their value whatever is written.

The block is reached through a simple register port with a write strobe, an address, write data and combinational read data. The alternate-function vector is also driven out in parallel to the pad logic. The commit mask resets to all ones, so the alternate-function register is fully writable until software narrows the mask.

Top module: `afsel_guard`

## Requirements
- R1: After reset the lock register reads 1, the commit register reads all ones (0xFF at the default width) and the alternate-function register reads 0.
- R2: A write of exactly 0x0ACCE551 to the lock register (offset 0x520) clears the lock, and a lock read then returns 0.
- R3: A write of any other value to the lock register sets the lock, and a lock read then returns 1 in bit 0 with all other bits 0.
- R4: A commit register write (offset 0x524) while unlocked stores the low pin-count bits of the data. The upper read bits are 0.
- R5: A commit register write while locked is dropped without any error and leaves the commit value unchanged.
- R6: The lock stays cleared across any number of commit writes, and is changed only by the next lock register write.
- R7: A write to the alternate-function register (offset 0x420) updates only the bits whose commit bit is 1. Every other bit keeps its value.
- R8: The commit and alternate-function registers read back their current values whether the block is locked or unlocked.
- R9: The alternate-function output vector always equals the alternate-function register value.
- R10: Reads of any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W (12) | Byte offset for reads and writes |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| alt_func | output | PIN_W (8) | Alternate-function select vector toward the pads |

## Verification
The bench builds the block with its default parameters: eight pins, a 12-bit offset and a 32-bit data path. At these values, partial commit masks such as a single nibble or all zeros can be checked against mixed alternate-function patterns. Near-miss keys are also tested: one differs from the key in the low bit and another in the top bit, so the bench can show that the whole 32-bit compare is used. Commit data with bits set above bit 7 shows that those bits are discarded.

// File: rtl/afsel_guard_pkg.sv
// Shared offsets and key for the keyed commit guard.
package afsel_guard_pkg;
    localparam int          OFS_W     = 12;
    localparam logic [11:0] OFS_AFSEL = 12'h420;
    localparam logic [11:0] OFS_LOCK  = 12'h520;
    localparam logic [11:0] OFS_CMT   = 12'h524;
    localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;
endpackage

// File: rtl/guard_lock.sv
// guard_lock: holds the lock flag. Any write to the lock register sets it,
// except a write of the exact key, which clears it.
// Assumes: wr_hit is a single-cycle qualified write to the lock offset.
module guard_lock #(
    parameter int          KEY_W = 32,
    parameter logic [31:0] KEY   = 32'h0ACC_E551
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [KEY_W-1:0] wdata,
    output logic             locked
);
    localparam logic [KEY_W-1:0] KEY_V = KEY_W'(KEY);

    logic armed;

    // Lock flag: set on reset and on any non-key write, cleared by the key.
    always_ff @(posedge clk) begin
        if (!rst_n)      locked <= 1'b1;
        else if (wr_hit) locked <= (wdata != KEY_V);
    end

    // Arms the checks one cycle after reset is released.
    always_ff @(posedge clk) armed <= rst_n;

    // R2
    key_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata == KEY_V) |=> !locked);
    // R3
    other_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata != KEY_V) |=> locked);
    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !wr_hit |=> $stable(locked));
endmodule

// File: rtl/guard_commit.sv
// guard_commit: commit mask register, loadable only while unlocked.
// Assumes: wr_hit is a qualified write to the commit offset.
module guard_commit #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             locked,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] mask
);
    logic armed;

    // Mask register: resets to all ones, loads only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mask <= '1;
        else if (wr_hit && !locked) mask <= wdata;
    end

    // Arms the checks one cycle after reset is released.
    always_ff @(posedge clk) armed <= rst_n;

    // R5
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (wr_hit && locked) |=> $stable(mask));
    // R4
    unlocked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !locked) |=> mask == $past(wdata));
endmodule

// File: rtl/guard_altfn.sv
// guard_altfn: alternate-function register with per-bit write enables
// taken from the commit mask. One flop per pin is generated.
// Assumes: wr_hit is a qualified write to the alternate-function offset.
module guard_altfn #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [PIN_W-1:0] mask,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] af
);
    logic armed;

    for (genvar i = 0; i < PIN_W; i++) begin : g_bit
        // Per-pin flop: written only when its commit bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n)                   af[i] <= 1'b0;
            else if (wr_hit && mask[i])   af[i] <= wdata[i];
        end
    end

    // Arms the checks one cycle after reset is released.
    always_ff @(posedge clk) armed <= rst_n;

    // R7
    masked_bits_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((af ^ $past(af)) & ~$past(mask)) == '0);
    // R7
    open_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((af ^ $past(wdata)) & $past(mask)) == '0);
endmodule

// File: rtl/afsel_guard.sv
// afsel_guard: top of the keyed commit guard. Decodes the register port,
// instantiates lock, commit and alternate-function stages, and muxes reads.
// Assumes: PIN_W <= DATA_W, and a write lasts one cycle per strobe.
module afsel_guard
    import afsel_guard_pkg::*;
#(
    parameter int          PIN_W  = 8,
    parameter int          ADDR_W = 12,
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = UNLOCK_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PIN_W-1:0]  alt_func
);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
    localparam logic [ADDR_W-1:0] A_CMT  = ADDR_W'(OFS_CMT);
    localparam logic [ADDR_W-1:0] A_AF   = ADDR_W'(OFS_AFSEL);

    logic             hit_lock, hit_cmt, hit_af;
    logic             locked;
    logic [PIN_W-1:0] mask;
    logic [PIN_W-1:0] af;
    logic             armed;

    // Address decode for writes.
    always_comb begin
        hit_lock = bus_wr && (bus_addr == A_LOCK);
        hit_cmt  = bus_wr && (bus_addr == A_CMT);
        hit_af   = bus_wr && (bus_addr == A_AF);
    end

    guard_lock #(.KEY_W(DATA_W), .KEY(KEY)) lock_i (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_lock),
        .wdata(bus_wdata), .locked(locked)
    );

    guard_commit #(.PIN_W(PIN_W)) cmt_i (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_cmt), .locked(locked),
        .wdata(bus_wdata[PIN_W-1:0]), .mask(mask)
    );

    guard_altfn #(.PIN_W(PIN_W)) af_i (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_af), .mask(mask),
        .wdata(bus_wdata[PIN_W-1:0]), .af(af)
    );

    assign alt_func = af;

    // Read mux: zero-extended register values, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_LOCK)      bus_rdata[0]         = locked;
        else if (bus_addr == A_CMT)  bus_rdata[PIN_W-1:0] = mask;
        else if (bus_addr == A_AF)   bus_rdata[PIN_W-1:0] = af;
    end

    // Arms the checks one cycle after reset is released.
    always_ff @(posedge clk) armed <= rst_n;

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (bus_wr && !hit_lock && !hit_cmt && !hit_af)
        |=> ($stable(alt_func) && $stable(locked) && $stable(mask)));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (locked && mask == '1 && alt_func == '0));
endmodule

// File: tb/afsel_guard_tb.sv
module afsel_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEY = 32'h0ACC_E551;
    localparam logic [11:0] A_AF = 12'h420, A_LOCK = 12'h520, A_CMT = 12'h524;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  alt_func;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    afsel_guard dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_func(alt_func)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_LOCK, v); check("R1 lock", v, 32'h1);
        rd(A_CMT, v);  check("R1 commit", v, 32'hFF);
        rd(A_AF, v);   check("R1 afsel", v, 32'h0);
        check("R1/R9 pins", {24'h0, alt_func}, 32'h0);
    endtask

    task automatic t_default_mask();
        logic [31:0] v;
        wr(A_AF, 32'hA5);
        rd(A_AF, v); check("R7 full mask write", v, 32'hA5);
        check("R9 pins", {24'h0, alt_func}, 32'hA5);
    endtask

    task automatic t_locked_commit();
        logic [31:0] v;
        wr(A_CMT, 32'h0F);
        rd(A_CMT, v); check("R5 locked commit drop", v, 32'hFF);
        rd(A_AF, v);  check("R8 afsel read locked", v, 32'hA5);
    endtask

    task automatic t_unlock_commit();
        logic [31:0] v;
        wr(A_LOCK, KEY);
        rd(A_LOCK, v); check("R2 unlocked", v, 32'h0);
        wr(A_CMT, 32'h0001_230F);
        rd(A_CMT, v); check("R4 low bits kept", v, 32'h0F);
        rd(A_LOCK, v); check("R6 still unlocked", v, 32'h0);
        wr(A_CMT, 32'h3C);
        rd(A_CMT, v); check("R6 second commit", v, 32'h3C);
        wr(A_CMT, 32'h0F);
        rd(A_CMT, v); check("R8 commit read unlocked", v, 32'h0F);
    endtask

    task automatic t_masked_af();
        logic [31:0] v;
        wr(A_AF, 32'h5A);
        rd(A_AF, v); check("R7 nibble mask", v, 32'hAA);
        check("R9 pins masked", {24'h0, alt_func}, 32'hAA);
    endtask

    task automatic t_relock();
        logic [31:0] v;
        wr(A_LOCK, 32'h0ACC_E550);
        rd(A_LOCK, v); check("R3 near key locks", v, 32'h1);
        wr(A_CMT, 32'hFF);
        rd(A_CMT, v); check("R5 drop after relock", v, 32'h0F);
        rd(A_AF, v);  check("R8 afsel read relocked", v, 32'hAA);
        wr(A_LOCK, KEY);
        wr(A_LOCK, 32'h8ACC_E551);
        rd(A_LOCK, v); check("R3 top bit differs", v, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(12'h428, 32'hFF);
        wr(12'h41C, 32'hFF);
        wr(12'h521, KEY);
        rd(12'h428, v); check("R10 unmapped read", v, 32'h0);
        rd(A_AF, v);    check("R10 afsel untouched", v, 32'hAA);
        rd(A_CMT, v);   check("R10 commit untouched", v, 32'h0F);
        rd(A_LOCK, v);  check("R10 lock untouched", v, 32'h1);
    endtask

    task automatic t_zero_mask();
        logic [31:0] v;
        wr(A_LOCK, KEY);
        wr(A_CMT, 32'h00);
        wr(A_LOCK, 32'h0);
        wr(A_AF, 32'h00);
        rd(A_AF, v); check("R7 zero mask", v, 32'hAA);
        check("R9 pins zero mask", {24'h0, alt_func}, 32'hAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_mask();
        t_locked_commit();
        t_unlock_commit();
        t_masked_af();
        t_relock();
        t_unmapped();
        t_zero_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule